// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block keeps a small associative record of loads that were hoisted above stores whose addresses could not be proven disjoint from their own. Each such load claims an entry that holds the register the value went to, the first byte it read and a size code for its width. Every store that goes by is compared with all live entries. Any entry whose bytes overlap the store's bytes is dropped, because the value in its register may now be stale.

Later, a check names a register. If a live entry for that register is still present, the check reports success and the hoisted work can be kept. If no entry is present, the check reports failure and asks for recovery. The caller computes the recovery target and runs the recovery code. The block does neither.

Each entry is a two-state machine.
- `ENT_FREE` holds nothing.
- A write moves it to `ENT_LIVE` (transition *claim*).
- A write to a live entry keeps it in `ENT_LIVE` with new contents (transition *refresh*).
- An overlapping store with no write in the same cycle moves it from `ENT_LIVE` back to `ENT_FREE` (transition *snoop kill*).
- Synchronous reset forces every entry to `ENT_FREE` (transition *clear*).

Top module: `spec_ld_tracker`

## Requirements
- R1: A synchronous active-high `rst` leaves every entry free. A check issued after reset, with no allocation since, reports failure.
- R2: When `alloc_vld` is high, the table records `alloc_tag`, `alloc_addr` and `alloc_size`. A check of that tag in any later cycle succeeds until the entry is invalidated or evicted.
- R3: The check response is registered and appears in the cycle after `chk_vld`. At that point `chk_done` is 1 and exactly one of `chk_ok` / `chk_recover` is 1. `chk_ok` is 1 exactly when a live entry holds `chk_tag`. In a cycle after no check, all three outputs are 0.
- R4: A store with `st_vld` covers bytes [`st_addr`, `st_addr` + 2^`st_size`). An entry covers [addr, addr + 2^size). The size codes are 0 = 1, 1 = 2, 2 = 4 and 3 = 8 bytes, and the end of each range is computed without wrap-around. Every live entry that shares at least one byte with the store becomes free in that cycle.
- R5: A store whose range shares no byte with an entry leaves that entry live, including a store that ends exactly where the entry begins or begins exactly where it ends.
- R6: An allocation whose tag matches a live entry overwrites that entry. Afterwards only the new address range matters, and at most one entry holds any tag.
- R7: An allocation with a new tag takes the lowest-numbered free entry. When all 8 entries are live, it takes the entry at a victim pointer. The pointer is 0 after reset and advances by one, modulo 8, on each such eviction only.
- R8: A check never changes the table. A successful check leaves its entry live, and a failed check leaves all other entries as they were.
- R9: Ordering within one cycle:
  - A store's invalidation is seen by a check in the same cycle.
  - An allocation in the same cycle as a check is not seen by that check.
  - An allocation in the same cycle as an overlapping store survives that store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_vld | input | 1 | Speculative load allocates an entry |
| alloc_tag | input | TAG_W | Destination register of the load |
| alloc_addr | input | ADDR_W | First byte address of the load |
| alloc_size | input | SIZE_W | Load width code (bytes = 2^code) |
| st_vld | input | 1 | Store snoop valid |
| st_addr | input | ADDR_W | First byte address of the store |
| st_size | input | SIZE_W | Store width code (bytes = 2^code) |
| chk_vld | input | 1 | Check request |
| chk_tag | input | TAG_W | Register being checked |
| chk_done | output | 1 | Check response valid, one cycle after request |
| chk_ok | output | 1 | Speculation held |
| chk_recover | output | 1 | Speculation broken, recovery requested |

## Verification
The bench sweeps every store offset around one entry and every pairing of store and entry size. This exposes a range compare that is off by one at either end: adjacent stores would then kill entries, or a one-byte overlap at the last byte would be missed. A fill-and-evict sequence frees one slot in the middle of a full table. A victim choice that ignored free slots, or a pointer that also advanced on non-evicting allocations, would then evict the wrong register. Same-cycle store-and-check, allocate-and-check and allocate-and-store cases catch an ordering that reads stale table contents or lets a store kill the entry being written.

// File: rtl/spec_ld_pkg.sv
package spec_ld_pkg;
    typedef enum logic {
        ENT_FREE = 1'b0,
        ENT_LIVE = 1'b1
    } ent_state_e;
endpackage

// File: rtl/sl_overlap.sv
// Byte-range intersection of two naturally sized accesses, no wrap-around.
module sl_overlap #(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 2
) (
    input  logic [ADDR_W-1:0] a_base,
    input  logic [SIZE_W-1:0] a_size,
    input  logic [ADDR_W-1:0] b_base,
    input  logic [SIZE_W-1:0] b_size,
    output logic              hit
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] a_lo, a_hi, b_lo, b_hi;

    always_comb begin
        a_lo = {1'b0, a_base};
        b_lo = {1'b0, b_base};
        a_hi = a_lo + (EXT_W'(1) << a_size);
        b_hi = b_lo + (EXT_W'(1) << b_size);
        hit  = (a_lo < b_hi) && (b_lo < a_hi);
    end
endmodule

// File: rtl/sl_entry.sv
// One table slot: a two-state machine plus its recorded load.
module sl_entry
    import spec_ld_pkg::*;
#(
    parameter int TAG_W  = 5,
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              kill,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SIZE_W-1:0] wr_size,
    output logic              live,
    output logic [TAG_W-1:0]  tag_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [SIZE_W-1:0] size_q
);
    ent_state_e state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ENT_FREE;
        else     state <= state_nx;
    end

    // transitions: claim, refresh, snoop kill
    always_comb begin
        state_nx = state;
        unique case (state)
            ENT_FREE: if (wr) state_nx = ENT_LIVE;
            ENT_LIVE: begin
                if (wr)        state_nx = ENT_LIVE;
                else if (kill) state_nx = ENT_FREE;
            end
        endcase
    end

    // recorded load
    always_ff @(posedge clk) begin
        if (wr) begin
            tag_q  <= wr_tag;
            addr_q <= wr_addr;
            size_q <= wr_size;
        end
    end

    // outputs
    always_comb live = (state == ENT_LIVE);
endmodule

// File: rtl/sl_victim.sv
// Picks the slot an allocation writes: same tag, else lowest free, else round-robin.
module sl_victim #(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic [ENTRIES-1:0] live,
    input  logic [ENTRIES-1:0] same,
    output logic [ENTRIES-1:0] wr_vec
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] pick;
    logic             found;
    logic             evict;

    always_comb begin
        wr_vec = '0;
        pick   = '0;
        found  = 1'b0;
        evict  = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!live[i]) begin
                pick  = IDX_W'(i);
                found = 1'b1;
            end
        end
        if (req) begin
            if (|same)      wr_vec = same;
            else if (found) wr_vec[pick] = 1'b1;
            else begin
                wr_vec[ptr_q] = 1'b1;
                evict         = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        ptr_q <= '0;
        else if (evict) ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
endmodule

// File: rtl/spec_ld_tracker.sv
module spec_ld_tracker #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 5,
    parameter int ADDR_W  = 16,
    parameter int SIZE_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_vld,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [SIZE_W-1:0] alloc_size,
    input  logic              st_vld,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SIZE_W-1:0] st_size,
    input  logic              chk_vld,
    input  logic [TAG_W-1:0]  chk_tag,
    output logic              chk_done,
    output logic              chk_ok,
    output logic              chk_recover
);
    logic [ENTRIES-1:0] live_vec, kill_vec, wr_vec, match_vec, same_vec, ovl_vec;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [ADDR_W-1:0]  addr_q [ENTRIES];
    logic [SIZE_W-1:0]  size_q [ENTRIES];
    logic               hit;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        sl_entry #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ent (
            .clk    (clk),
            .rst    (rst),
            .wr     (wr_vec[g]),
            .kill   (kill_vec[g]),
            .wr_tag (alloc_tag),
            .wr_addr(alloc_addr),
            .wr_size(alloc_size),
            .live   (live_vec[g]),
            .tag_q  (tag_q[g]),
            .addr_q (addr_q[g]),
            .size_q (size_q[g])
        );

        sl_overlap #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ovl (
            .a_base(addr_q[g]),
            .a_size(size_q[g]),
            .b_base(st_addr),
            .b_size(st_size),
            .hit   (ovl_vec[g])
        );

        always_comb begin
            kill_vec[g]  = st_vld && live_vec[g] && ovl_vec[g];
            match_vec[g] = live_vec[g] && (tag_q[g] == chk_tag);
            same_vec[g]  = live_vec[g] && (tag_q[g] == alloc_tag);
        end
    end

    sl_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk   (clk),
        .rst   (rst),
        .req   (alloc_vld),
        .live  (live_vec),
        .same  (same_vec),
        .wr_vec(wr_vec)
    );

    // a same-cycle store invalidation is visible to the check
    always_comb hit = |(match_vec & ~kill_vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_done    <= 1'b0;
            chk_ok      <= 1'b0;
            chk_recover <= 1'b0;
        end else begin
            chk_done    <= chk_vld;
            chk_ok      <= chk_vld && hit;
            chk_recover <= chk_vld && !hit;
        end
    end
endmodule

// File: rtl/sl_checker.sv
module sl_checker #(
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               alloc_vld,
    input logic               st_vld,
    input logic               chk_vld,
    input logic               chk_done,
    input logic               chk_ok,
    input logic               chk_recover,
    input logic [ENTRIES-1:0] live_vec,
    input logic [ENTRIES-1:0] kill_vec,
    input logic [ENTRIES-1:0] wr_vec,
    input logic [ENTRIES-1:0] match_vec
);
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (live_vec == '0));

    p_alloc_live_r2: assert property (@(posedge clk) disable iff (rst)
        (|wr_vec) |=> ((live_vec & $past(wr_vec)) == $past(wr_vec)));

    p_resp_excl_r3: assert property (@(posedge clk) disable iff (rst)
        chk_done |-> (chk_ok != chk_recover));

    p_resp_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !chk_done |-> (!chk_ok && !chk_recover));

    p_resp_timing_r3: assert property (@(posedge clk) disable iff (rst)
        chk_vld |=> chk_done);

    p_kill_r4: assert property (@(posedge clk) disable iff (rst)
        (|(kill_vec & ~wr_vec)) |=> ((live_vec & $past(kill_vec & ~wr_vec)) == '0));

    p_unique_tag_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

    p_one_slot_r7: assert property (@(posedge clk) disable iff (rst)
        alloc_vld |-> ($countones(wr_vec) == 1));

    p_no_stray_write_r7: assert property (@(posedge clk) disable iff (rst)
        !alloc_vld |-> (wr_vec == '0));

    p_check_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!alloc_vld && !st_vld) |=> (live_vec == $past(live_vec)));
endmodule

bind spec_ld_tracker sl_checker #(.ENTRIES(ENTRIES)) u_sl_checker (
    .clk        (clk),
    .rst        (rst),
    .alloc_vld  (alloc_vld),
    .st_vld     (st_vld),
    .chk_vld    (chk_vld),
    .chk_done   (chk_done),
    .chk_ok     (chk_ok),
    .chk_recover(chk_recover),
    .live_vec   (live_vec),
    .kill_vec   (kill_vec),
    .wr_vec     (wr_vec),
    .match_vec  (match_vec)
);

// File: tb/spec_ld_tracker_bench.sv
`timescale 1ns/1ps
module spec_ld_tracker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alloc_vld = 1'b0;
    logic [4:0]  alloc_tag = '0;
    logic [15:0] alloc_addr = '0;
    logic [1:0]  alloc_size = '0;
    logic        st_vld = 1'b0;
    logic [15:0] st_addr = '0;
    logic [1:0]  st_size = '0;
    logic        chk_vld = 1'b0;
    logic [4:0]  chk_tag = '0;
    logic        chk_done, chk_ok, chk_recover;

    int checks = 0;
    int failures = 0;
    logic r_done, r_ok, r_rec;

    always #5 clk = ~clk;

    spec_ld_tracker u_spec_ld_tracker (
        .clk(clk), .rst(rst),
        .alloc_vld(alloc_vld), .alloc_tag(alloc_tag),
        .alloc_addr(alloc_addr), .alloc_size(alloc_size),
        .st_vld(st_vld), .st_addr(st_addr), .st_size(st_size),
        .chk_vld(chk_vld), .chk_tag(chk_tag),
        .chk_done(chk_done), .chk_ok(chk_ok), .chk_recover(chk_recover)
    );

    // One cycle: inputs applied 1 ns after an edge, response sampled 1 ns after the next.
    task automatic step(input logic av, input logic [4:0] at, input logic [15:0] aa,
                        input logic [1:0] as, input logic sv, input logic [15:0] sa,
                        input logic [1:0] ss, input logic cv, input logic [4:0] ct);
        alloc_vld = av; alloc_tag = at; alloc_addr = aa; alloc_size = as;
        st_vld = sv; st_addr = sa; st_size = ss;
        chk_vld = cv; chk_tag = ct;
        @(posedge clk); #1;
        r_done = chk_done; r_ok = chk_ok; r_rec = chk_recover;
        alloc_vld = 1'b0; st_vld = 1'b0; chk_vld = 1'b0;
    endtask

    task automatic alloc(input logic [4:0] t, input logic [15:0] a, input logic [1:0] s);
        step(1'b1, t, a, s, 1'b0, '0, '0, 1'b0, '0);
    endtask

    task automatic store(input logic [15:0] a, input logic [1:0] s);
        step(1'b0, '0, '0, '0, 1'b1, a, s, 1'b0, '0);
    endtask

    task automatic expect_resp(input string req, input logic exp_ok);
        checks++;
        if (r_done !== 1'b1 || r_ok !== exp_ok || r_rec !== !exp_ok) begin
            failures++;
            $display("FAIL %s: done/ok/recover = %b/%b/%b expected 1/%b/%b",
                     req, r_done, r_ok, r_rec, exp_ok, !exp_ok);
        end
    endtask

    task automatic check(input logic [4:0] t, input logic exp_ok, input string req);
        step(1'b0, '0, '0, '0, 1'b0, '0, '0, 1'b1, t);
        expect_resp(req, exp_ok);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, actual hung expected finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();

        // R1: empty after reset
        check(5'd0, 1'b0, "R1 empty after reset");
        check(5'd7, 1'b0, "R1 empty after reset");

        // R3: idle cycle gives no response
        step(1'b0, '0, '0, '0, 1'b0, '0, '0, 1'b0, '0);
        checks++;
        if (r_done !== 1'b0 || r_ok !== 1'b0 || r_rec !== 1'b0) begin
            failures++;
            $display("FAIL R3 idle: done/ok/recover = %b/%b/%b expected 0/0/0", r_done, r_ok, r_rec);
        end

        // R2 / R3: allocate then check
        alloc(5'd1, 16'd16, 2'd0);
        check(5'd1, 1'b1, "R2 allocated tag found");
        check(5'd2, 1'b0, "R3 other tag absent");

        // R4 / R5: sweep store offsets and sizes against an entry at 16
        for (int es = 0; es < 4; es++) begin
            for (int sa = 8; sa < 32; sa++) begin
                for (int ss = 0; ss < 4; ss++) begin
                    bit ov;
                    ov = (sa < 16 + (1 << es)) && (16 < sa + (1 << ss));
                    alloc(5'd1, 16'd16, 2'(es));
                    store(16'(sa), 2'(ss));
                    check(5'd1, !ov, ov ? "R4 overlapping store kills" : "R5 disjoint store keeps");
                end
            end
        end

        // R6: same tag replaces range
        alloc(5'd3, 16'd100, 2'd2);
        alloc(5'd3, 16'd200, 2'd2);
        store(16'd100, 2'd3);
        check(5'd3, 1'b1, "R6 old range no longer tracked");
        store(16'd200, 2'd0);
        check(5'd3, 1'b0, "R6 new range tracked");

        // R7: fill, evict round-robin, reuse freed slot
        do_reset();
        for (int i = 0; i < 8; i++) alloc(5'(i), 16'(32 * i), 2'd3);
        for (int i = 0; i < 8; i++) check(5'(i), 1'b1, "R7 all eight slots held");
        alloc(5'd8, 16'd1000, 2'd3);            // evicts slot 0 (tag 0)
        alloc(5'd9, 16'd1100, 2'd3);            // evicts slot 1 (tag 1)
        store(16'd160, 2'd0);                   // kills tag 5 (slot 5)
        alloc(5'd10, 16'd1200, 2'd3);           // takes free slot 5
        alloc(5'd11, 16'd1300, 2'd3);           // evicts slot 2 (tag 2)
        check(5'd0, 1'b0, "R7 first eviction");
        check(5'd1, 1'b0, "R7 second eviction");
        check(5'd2, 1'b0, "R7 pointer skipped free-slot allocation");
        check(5'd5, 1'b0, "R4 killed by store");
        check(5'd3, 1'b1, "R7 survivor");
        check(5'd4, 1'b1, "R7 survivor");
        check(5'd6, 1'b1, "R7 survivor");
        check(5'd7, 1'b1, "R7 survivor");
        check(5'd8, 1'b1, "R7 new entry");
        check(5'd9, 1'b1, "R7 new entry");
        check(5'd10, 1'b1, "R7 free slot reused");
        check(5'd11, 1'b1, "R7 new entry");

        // R8: checks leave the table alone
        check(5'd3, 1'b1, "R8 repeated success");
        check(5'd3, 1'b1, "R8 repeated success");
        check(5'd20, 1'b0, "R8 failed check");
        check(5'd4, 1'b1, "R8 unaffected by failed check");

        // R9: same-cycle orderings
        do_reset();
        alloc(5'd12, 16'd64, 2'd2);
        step(1'b0, '0, '0, '0, 1'b1, 16'd66, 2'd0, 1'b1, 5'd12);
        expect_resp("R9 store seen by same-cycle check", 1'b0);
        step(1'b1, 5'd13, 16'd80, 2'd1, 1'b0, '0, '0, 1'b1, 5'd13);
        expect_resp("R9 allocation not seen by same-cycle check", 1'b0);
        check(5'd13, 1'b1, "R9 allocation visible next cycle");
        step(1'b1, 5'd14, 16'd96, 2'd3, 1'b1, 16'd96, 2'd3, 1'b0, '0);
        check(5'd14, 1'b1, "R9 allocation survives same-cycle store");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule